// File: doc/BRIEF.md
# Per-Hart Software Interrupt Doorbell Bank

This block holds one 32-bit word for each hart behind a small memory-mapped port, and each word drives the software-interrupt line of its hart. Software running on one hart writes another hart's word to signal it. The line stays asserted until it is cleared.

A parameter fixes the flavour of the bank when it is built. In the plain flavour, each word is an ordinary read/write pending bit, and software both raises and lowers the line. In the doorbell flavour, a bus write can only set the bit and every read returns zero. The line is lowered only from the hart side, through a per-hart clear input.

Only aligned 32-bit accesses are decoded; any other access reads as zero and writes nothing. Read data comes back one cycle after the request.

Top module: `soft_irq_bank`

## Requirements
- R1: The word of hart i sits at byte offset 4*i. A valid write with data bit 0 set raises `sw_irq[i]` from the cycle after the write and touches no other hart, in both flavours.
- R2: In the plain flavour (MODE = MODE_PLAIN), a valid write with data bit 0 clear lowers `sw_irq[i]` in the cycle after the write.
- R3: In the doorbell flavour (MODE = MODE_DOORBELL), a write with data bit 0 clear leaves the line unchanged.
- R4: Every read request (`bus_valid`=1, `bus_write`=0) produces `bus_rvalid`=1 in the next cycle. In the plain flavour, a valid read returns the hart's pending bit in bit 0 of `bus_rdata`.
- R5: In the doorbell flavour, every read returns zero.
- R6: An access is valid only when `bus_size` = 2'b10 (4 bytes), `bus_addr[1:0]` = 0 and `bus_addr`/4 is less than NUM_HARTS. Any other read returns zero, and any other write changes no line.
- R7: Bits 31:1 of every word read as zero and are ignored on write. In the plain flavour, writing 0xFFFF_FFFE therefore lowers the line.
- R8: In the doorbell flavour, `hart_clr[i]`=1 lowers `sw_irq[i]` in the next cycle. In the plain flavour, `hart_clr` has no effect.
- R9: In the doorbell flavour, a set write and a clear for the same hart in the same cycle leave the line raised.
- R10: While `rst_n` is low, every `sw_irq` line, `bus_rvalid` and `bus_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the bank |
| bus_size | input | 2 | Access size code; 2'b10 = 4 bytes |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| hart_clr | input | NUM_HARTS | Per-hart clear pulse (doorbell flavour only) |
| sw_irq | output | NUM_HARTS | Per-hart software-interrupt lines |

## Verification
The bench builds two instances that share one bus. The first is a plain bank with four harts. The second is a doorbell bank with three harts, so the offset 12 still decodes inside the address field but lies past the hart count. With both flavours present, the same write can be seen to lower a line in one bank and leave it alone in the other. A clear pulse can likewise be seen to act in one bank and be ignored in the other. The odd hart count exercises the range check at an address that bit slicing alone would accept.

// File: rtl/soft_irq_pkg.sv
package soft_irq_pkg;

    localparam int WORD_W = 32;
    localparam logic [1:0] SIZE_WORD = 2'b10;

    typedef enum logic {
        MODE_PLAIN    = 1'b0,
        MODE_DOORBELL = 1'b1
    } sip_mode_e;

    // decoded access for one cycle
    typedef struct packed {
        logic wr;    // valid write to some hart
        logic rd;    // any read request
        logic wbit;  // data bit 0
    } sip_acc_t;

    typedef struct packed {
        logic pend;
    } sip_cell_t;

    typedef struct packed {
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
    } sip_rd_t;

endpackage

// File: rtl/soft_irq_decode.sv
module soft_irq_decode
    import soft_irq_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [WORD_W-1:0]    bus_wdata,
    output sip_acc_t             acc,
    output logic [NUM_HARTS-1:0] sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             shape_ok;
    logic             in_range;
    logic             ok;

    always_comb begin
        idx      = bus_addr[ADDR_W-1:2];
        shape_ok = (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00);
        in_range = ({{(32-IDX_W){1'b0}}, idx} < 32'(NUM_HARTS));
        ok       = bus_valid && shape_ok && in_range;

        acc.wr   = ok && bus_write;
        acc.rd   = bus_valid && !bus_write;
        acc.wbit = bus_wdata[0];
    end

    for (genvar k = 0; k < NUM_HARTS; k++) begin : g_sel
        assign sel[k] = ok && (idx == IDX_W'(k));
    end

endmodule

// File: rtl/soft_irq_cell.sv
module soft_irq_cell
    import soft_irq_pkg::*;
#(
    parameter sip_mode_e MODE = MODE_PLAIN
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel,
    input  sip_acc_t acc,
    input  logic     clr,
    output logic     pend
);
    sip_cell_t st_d, st_q;

    if (MODE == MODE_PLAIN) begin : g_plain
        always_comb begin
            st_d = st_q;
            if (sel && acc.wr) begin
                st_d.pend = acc.wbit;
            end
        end
    end else begin : g_doorbell
        always_comb begin
            st_d = st_q;
            if (clr) begin
                st_d.pend = 1'b0;
            end
            // a set in the same cycle overrides the clear
            if (sel && acc.wr && acc.wbit) begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/soft_irq_rdport.sv
module soft_irq_rdport
    import soft_irq_pkg::*;
#(
    parameter int        NUM_HARTS = 4,
    parameter sip_mode_e MODE      = MODE_PLAIN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  sip_acc_t             acc,
    input  logic [NUM_HARTS-1:0] sel,
    input  logic [NUM_HARTS-1:0] pend,
    output logic [WORD_W-1:0]    rdata,
    output logic                 rvalid
);
    sip_rd_t rd_d, rd_q;

    always_comb begin
        rd_d        = '0;
        rd_d.rvalid = acc.rd;
        if (MODE == MODE_PLAIN && acc.rd) begin
            rd_d.rdata[0] = |(sel & pend);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata  = rd_q.rdata;
    assign rvalid = rd_q.rvalid;

endmodule

// File: rtl/soft_irq_bank.sv
module soft_irq_bank
    import soft_irq_pkg::*;
#(
    parameter int        NUM_HARTS = 4,
    parameter int        ADDR_W    = 8,
    parameter sip_mode_e MODE      = MODE_PLAIN
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    input  logic [NUM_HARTS-1:0] hart_clr,
    output logic [NUM_HARTS-1:0] sw_irq
);
    sip_acc_t             acc;
    logic [NUM_HARTS-1:0] sel;

    soft_irq_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W)
    ) decode_i (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .acc       (acc),
        .sel       (sel)
    );

    for (genvar k = 0; k < NUM_HARTS; k++) begin : g_hart
        soft_irq_cell #(
            .MODE (MODE)
        ) cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel[k]),
            .acc   (acc),
            .clr   (hart_clr[k]),
            .pend  (sw_irq[k])
        );
    end

    soft_irq_rdport #(
        .NUM_HARTS (NUM_HARTS),
        .MODE      (MODE)
    ) rdport_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .sel    (sel),
        .pend   (sw_irq),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid)
    );

endmodule

// File: rtl/soft_irq_bank_chk.sv
module soft_irq_bank_chk
    import soft_irq_pkg::*;
#(
    parameter int        NUM_HARTS = 4,
    parameter int        ADDR_W    = 8,
    parameter sip_mode_e MODE      = MODE_PLAIN
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [1:0]           bus_size,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 bus_rvalid,
    input logic [NUM_HARTS-1:0] hart_clr,
    input logic [NUM_HARTS-1:0] sw_irq
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;
    logic any_hit;
    logic [NUM_HARTS-1:0] hit;

    assign aligned = bus_valid && (bus_size == 2'b10) && (bus_addr[1:0] == 2'b00);
    assign any_hit = |hit;

    for (genvar k = 0; k < NUM_HARTS; k++) begin : g_h
        assign hit[k] = aligned && (bus_addr[ADDR_W-1:2] == IDX_W'(k));

        p_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[k] && bus_write && bus_wdata[0]) |=> sw_irq[k]);

        if (MODE == MODE_PLAIN) begin : g_plain
            p_lower_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[k] && bus_write && !bus_wdata[0]) |=> !sw_irq[k]);
            p_clr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !(hit[k] && bus_write) |=> $stable(sw_irq[k]));
        end else begin : g_door
            p_zero_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (hit[k] && bus_write && !bus_wdata[0] && !hart_clr[k]) |=> $stable(sw_irq[k]));
            p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (hart_clr[k] && !(hit[k] && bus_write && bus_wdata[0])) |=> !sw_irq[k]);
            p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (hart_clr[k] && hit[k] && bus_write && bus_wdata[0]) |=> sw_irq[k]);
        end
    end

    p_rvalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    p_door_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_DOORBELL && bus_rvalid) |-> (bus_rdata == 32'h0));

    p_bad_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !any_hit && (MODE == MODE_PLAIN || hart_clr == '0))
        |=> $stable(sw_irq));

    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[31:1] == 31'h0));

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |-> (sw_irq == '0 && !bus_rvalid && bus_rdata == 32'h0));

endmodule

bind soft_irq_bank soft_irq_bank_chk #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W),
    .MODE      (MODE)
) chk_i (.*);

// File: tb/soft_irq_bank_tb_top.sv
module soft_irq_bank_tb_top;
    import soft_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  clr_s = '0;
    logic [3:0]  clr_m;
    logic [31:0] rdata_m, rdata_s;
    logic        rvalid_m, rvalid_s;
    logic [3:0]  irq_m;
    logic [2:0]  irq_s;

    logic [3:0]  exp_m = '0;
    logic [2:0]  exp_s = '0;
    int          total = 0;
    int          bad = 0;

    assign clr_m = {clr_s[0], clr_s};

    always #5 clk = ~clk;

    soft_irq_bank #(.NUM_HARTS(4), .ADDR_W(8), .MODE(MODE_PLAIN)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_m), .bus_rvalid(rvalid_m), .hart_clr(clr_m), .sw_irq(irq_m));

    soft_irq_bank #(.NUM_HARTS(3), .ADDR_W(8), .MODE(MODE_DOORBELL)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_s), .bus_rvalid(rvalid_s), .hart_clr(clr_s), .sw_irq(irq_s));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_lines(input string tag);
        chk({tag, " plain lines"}, 32'(irq_m), 32'(exp_m));
        chk({tag, " doorbell lines"}, 32'(irq_s), 32'(exp_s));
    endtask

    // one bus cycle plus optional doorbell clears; results checked after it
    task automatic access(input string tag, input logic wr, input logic [7:0] addr,
                          input logic [1:0] size, input logic [31:0] data, input logic [2:0] clr);
        logic        shape;
        logic [5:0]  idx;
        logic        ok_m, ok_s;
        logic [31:0] rd_exp_m;
        shape = (size == 2'b10) && (addr[1:0] == 2'b00);
        idx   = addr[7:2];
        ok_m  = shape && (idx < 6'd4);
        ok_s  = shape && (idx < 6'd3);
        rd_exp_m = (!wr && ok_m) ? {31'h0, exp_m[idx[1:0]]} : 32'h0;
        if (wr && ok_m) exp_m[idx[1:0]] = data[0];
        exp_s = exp_s & ~clr;
        if (wr && ok_s && data[0]) exp_s[idx[1:0]] = 1'b1;

        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = addr;
        bus_size = size; bus_wdata = data; clr_s = clr;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; clr_s = '0;
        check_lines(tag);
        chk({tag, " rvalid"}, 32'({rvalid_m, rvalid_s}), wr ? 32'h0 : 32'h3);
        if (!wr) begin
            chk({tag, " plain rdata"}, rdata_m, rd_exp_m);
            chk({tag, " doorbell rdata"}, rdata_s, 32'h0);
        end
    endtask

    task automatic idle_clr(input string tag, input logic [2:0] clr);
        exp_s = exp_s & ~clr;
        @(negedge clk);
        clr_s = clr;
        @(posedge clk);
        @(negedge clk);
        clr_s = '0;
        check_lines(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        exp_m = '0; exp_s = '0;
        repeat (2) @(negedge clk);
        check_lines(tag);
        chk({tag, " rvalid"}, 32'({rvalid_m, rvalid_s}), 32'h0);
        chk({tag, " rdata"}, rdata_m | rdata_s, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_reset;     do_reset("R10 reset state"); endtask

    task automatic t_set;
        for (int k = 0; k < 4; k++) access("R1 set word", 1'b1, 8'(4 * k), 2'b10, 32'h1, 3'b000);
    endtask

    task automatic t_plain_clear;
        access("R2/R3 write zero hart1", 1'b1, 8'h04, 2'b10, 32'h0, 3'b000);
    endtask

    task automatic t_reads;
        for (int k = 0; k < 4; k++) access("R4/R5 read word", 1'b0, 8'(4 * k), 2'b10, 32'h0, 3'b000);
    endtask

    task automatic t_bad;
        access("R6 clear hart2", 1'b1, 8'h08, 2'b10, 32'h0, 3'b000);
        access("R6 misaligned write", 1'b1, 8'h09, 2'b10, 32'h1, 3'b000);
        access("R6 short write", 1'b1, 8'h08, 2'b01, 32'h1, 3'b000);
        access("R6 out of range write", 1'b1, 8'h40, 2'b10, 32'h1, 3'b000);
        access("R6 misaligned read", 1'b0, 8'h02, 2'b10, 32'h0, 3'b000);
        access("R6 size read", 1'b0, 8'h00, 2'b11, 32'h0, 3'b000);
        access("R6 beyond count read", 1'b0, 8'h0c, 2'b10, 32'h0, 3'b000);
    endtask

    task automatic t_upper;
        access("R7 upper bits set, bit0 clear", 1'b1, 8'h00, 2'b10, 32'hFFFF_FFFE, 3'b000);
        access("R7 all ones", 1'b1, 8'h08, 2'b10, 32'hFFFF_FFFF, 3'b000);
        access("R7 read back", 1'b0, 8'h08, 2'b10, 32'h0, 3'b000);
    endtask

    task automatic t_hart_clr;
        idle_clr("R8 clear hart0", 3'b001);
        idle_clr("R8 clear hart2", 3'b100);
    endtask

    task automatic t_set_wins;
        access("R9 set and clear same hart", 1'b1, 8'h04, 2'b10, 32'h1, 3'b010);
        access("R9 set hart0 clear hart1", 1'b1, 8'h00, 2'b10, 32'h1, 3'b010);
    endtask

    task automatic t_reset_mid;
        access("R10 preset hart1", 1'b1, 8'h04, 2'b10, 32'h1, 3'b000);
        do_reset("R10 reset while pending");
    endtask

    initial begin
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_set();
        t_plain_clear();
        t_reads();
        t_bad();
        t_upper();
        t_hart_clr();
        t_set_wins();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule